// File: doc/BRIEF.md
# Serial TDM Output Advancement Unit

This block drives one time-division-multiplexed serial output stream. Its bit edges can be pulled earlier than the nominal frame-aligned timing by a small, programmable number of system-clock cycles. Everything runs on one fast system clock. The intended clock is 131.072 MHz, which gives about 7.6 ns per cycle. A frame pulse marks each frame boundary. The default frame is 16384 cycles, or 125 µs.

A stream-rate select chooses 2, 4, 8, 16 or 32 Mbps. At those rates one bit lasts 64, 32, 16, 8 or 4 cycles. A 16-bit configuration word written through a simple write strobe holds a 2-bit advancement code. Parallel channel bytes are fetched through a one-cycle request that carries the channel index. The byte is returned on the following cycle and shifted out most significant bit first.

Advancement works by loading the in-frame cycle position with the advance amount at the frame pulse. The first bit of channel 0 therefore starts that many cycles before the boundary, and a steady periodic frame wraps cleanly. The code and the rate are both adopted only at a frame pulse, so no frame ever mixes two timings.

Top module: `tdm_adv_tx`

## Requirements
- R1: The advancement code is bit 1:0 of `cfg_wdata`, captured when `cfg_we` is high. Bits 15:2 have no effect on any output. After reset the code is 00.
- R2: With code 00, the cycle after an edge that samples `fp_i` high is in-frame position 0, the first cycle of bit 7 (the MSB) of channel 0. There is no advancement.
- R3: With `rate_sel` 0, 1, 2 or 3 (2, 4, 8, 16 Mbps), codes 01, 10 and 11 make the cycle after the frame pulse position 2, 4 or 6. Every bit edge then comes that many cycles early.
- R4: With `rate_sel` 4 (32 Mbps), codes 01, 10 and 11 give positions 1, 2 and 3. `rate_sel` values 5, 6 and 7 are treated as 32 Mbps.
- R5: A written code and the `rate_sel` value take effect only at a frame pulse. A write in the same cycle as a pulse is applied at the following pulse.
- R6: One bit lasts 64, 32, 16, 8 or 4 cycles for `rate_sel` 0 to 4. The position counts up by one each cycle and wraps modulo the frame length.
- R7: The output byte is sent MSB first. `ser_o` changes only at a bit boundary or in the cycle after a frame pulse.
- R8: `byte_req` is high for exactly one cycle, when the position modulo one byte time equals seven bit times. During that cycle `byte_chan` gives the index of the next channel, which wraps at the last channel. `byte_data` is taken in the cycle after the request and sent from the next byte boundary.
- R9: During and after reset, `ser_o` is 0 and `byte_req` is 0 until the first request position is reached. The rate is 2 Mbps and the position is 0.
- R10: A frame pulse arriving mid-frame restarts the frame at once. The byte last fetched starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Frame boundary pulse, one cycle |
| rate_sel | input | 3 | Stream rate: 0=2, 1=4, 2=8, 3=16, 4..7=32 Mbps |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word, code in bits 1:0 |
| byte_req | output | 1 | One-cycle request for the next channel byte |
| byte_chan | output | CH_W | Channel index of the requested byte |
| byte_data | input | 8 | Channel byte, valid the cycle after the request |
| ser_o | output | 1 | Serial stream output |

## Verification
A configuration write and a frame pulse can land in the same cycle. The bench provokes this by writing code 11 exactly as a pulse arrives while code 01 is pending. It expects the first request after that pulse to show the old 1-cycle advance, and the request after the next pulse to show the new 3-cycle advance. A byte request can also collide with a mid-frame pulse that restarts the frame. Both collisions are judged every cycle against a behavioural model of position, fetched byte and output bit, and also through directly measured pulse-to-request distances.

// File: rtl/tdm_adv_pkg.sv
package tdm_adv_pkg;

   typedef enum logic [2:0] {
      RATE_2M  = 3'd0,
      RATE_4M  = 3'd1,
      RATE_8M  = 3'd2,
      RATE_16M = 3'd3,
      RATE_32M = 3'd4
   } rate_e;

   // Selector values above the fastest rate fold onto it
   function automatic rate_e rate_decode(input logic [2:0] sel);
      if (sel >= 3'd4) return RATE_32M;
      return rate_e'(sel);
   endfunction

   // log2 of cycles per bit; the fastest rate uses fast_log
   function automatic int bit_log(input rate_e r, input int fast_log);
      return fast_log + 4 - int'(r);
   endfunction

   function automatic int adv_cycles(input int code, input rate_e r,
                                     input int slow_step, input int fast_step);
      return code * ((r == RATE_32M) ? fast_step : slow_step);
   endfunction

endpackage

// File: rtl/tdm_adv_cfg.sv
module tdm_adv_cfg
   import tdm_adv_pkg::*;
#(
   parameter int REG_W     = 16,
   parameter int CODE_W    = 2,
   parameter int ADV_W     = 3,
   parameter int SLOW_STEP = 2,
   parameter int FAST_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_i,
   input  logic [2:0]        rate_sel,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [CODE_W-1:0] code_pend,
   output logic [CODE_W-1:0] code_cur,
   output rate_e             rate_cur,
   output rate_e             rate_nxt,
   output logic [ADV_W-1:0]  adv_load
);

   rate_e rate_in;
   logic  unused_rsvd;

   assign rate_in     = rate_decode(rate_sel);
   assign rate_nxt    = fp_i ? rate_in : rate_cur;
   // the advance loaded at a pulse uses the code pending before this edge
   assign adv_load    = ADV_W'(adv_cycles(int'(code_pend), rate_in, SLOW_STEP, FAST_STEP));
   assign unused_rsvd = ^cfg_wdata[REG_W-1:CODE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_pend <= '0;
         code_cur  <= '0;
         rate_cur  <= RATE_2M;
      end else begin
         if (cfg_we) code_pend <= cfg_wdata[CODE_W-1:0];
         if (fp_i) begin
            code_cur <= code_pend;
            rate_cur <= rate_in;
         end
      end
   end

endmodule

// File: rtl/tdm_adv_timer.sv
module tdm_adv_timer #(
   parameter int POS_W = 14,
   parameter int ADV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fp_i,
   input  logic [ADV_W-1:0] adv_load,
   output logic [POS_W-1:0] pos_nxt,
   output logic [POS_W-1:0] pos_q
);

   // frame length is a power of two, so plain increment wraps
   assign pos_nxt = fp_i ? POS_W'(adv_load) : pos_q + POS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_nxt;
   end

endmodule

// File: rtl/tdm_adv_shifter.sv
module tdm_adv_shifter
   import tdm_adv_pkg::*;
#(
   parameter int POS_W     = 14,
   parameter int FRAME_CYC = 16384,
   parameter int FAST_LOG  = 2,
   parameter int BYTE_W    = 8,
   parameter int CH_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_i,
   input  logic [POS_W-1:0]  pos_q,
   input  logic [POS_W-1:0]  pos_nxt,
   input  rate_e             rate_cur,
   input  rate_e             rate_nxt,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              byte_req,
   output logic [CH_W-1:0]   byte_chan,
   output logic              ser_o
);

   localparam int BYTE_LOG = $clog2(BYTE_W);

   function automatic logic [POS_W-1:0] low_mask(input int n);
      return (POS_W'(1) << n) - POS_W'(1);
   endfunction

   int                bl_cur, bl_nxt, byl_cur, byl_nxt;
   logic [POS_W-1:0]  chan_full, chan_mask;
   logic              load_c, shift_c, req_d;
   logic [BYTE_W-1:0] hold_q, sh_q;

   always_comb begin
      bl_cur  = bit_log(rate_cur, FAST_LOG);
      bl_nxt  = bit_log(rate_nxt, FAST_LOG);
      byl_cur = bl_cur + BYTE_LOG;
      byl_nxt = bl_nxt + BYTE_LOG;
   end

   // request at the start of the last bit of the current byte
   assign byte_req  = (pos_q & low_mask(byl_cur)) == (POS_W'(BYTE_W - 1) << bl_cur);
   assign chan_full = (pos_q >> byl_cur) + POS_W'(1);
   assign chan_mask = POS_W'(FRAME_CYC - 1) >> byl_cur;
   assign byte_chan = CH_W'(chan_full & chan_mask);

   assign load_c  = fp_i || ((pos_nxt & low_mask(byl_nxt)) == '0);
   assign shift_c = (pos_nxt & low_mask(bl_nxt)) == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d  <= 1'b0;
         hold_q <= '0;
         sh_q   <= '0;
      end else begin
         req_d <= byte_req;
         if (req_d) hold_q <= byte_data;
         if (load_c)       sh_q <= hold_q;
         else if (shift_c) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign ser_o = sh_q[BYTE_W-1];

endmodule

// File: rtl/tdm_adv_tx.sv
module tdm_adv_tx
   import tdm_adv_pkg::*;
#(
   parameter int FRAME_CYC = 16384,
   parameter int FAST_CPB  = 4,
   parameter int BYTE_W    = 8,
   parameter int REG_W     = 16,
   parameter int CODE_W    = 2,
   parameter int SLOW_STEP = 2,
   parameter int FAST_STEP = 1,
   localparam int POS_W    = $clog2(FRAME_CYC),
   localparam int FAST_LOG = $clog2(FAST_CPB),
   localparam int CH_W     = POS_W - FAST_LOG - $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_i,
   input  logic [2:0]        rate_sel,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              byte_req,
   output logic [CH_W-1:0]   byte_chan,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              ser_o
);

   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int MAX_STEP = (SLOW_STEP > FAST_STEP) ? SLOW_STEP : FAST_STEP;
   localparam int ADV_W    = $clog2(MAX_CODE * MAX_STEP + 1);

   generate
      if ((FRAME_CYC & (FRAME_CYC - 1)) != 0) begin : g_bad_frame
         $error("frame length must be a power of two");
      end
      if ((FAST_CPB & (FAST_CPB - 1)) != 0 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_pow
         $error("cycles per bit and byte width must be powers of two");
      end
      if (FRAME_CYC < BYTE_W * (FAST_CPB << 4)) begin : g_bad_len
         $error("frame too short for one byte at the slowest rate");
      end
      if (MAX_CODE * FAST_STEP >= FAST_CPB || MAX_CODE * SLOW_STEP >= 2 * FAST_CPB) begin : g_bad_adv
         $error("advance must stay inside the first bit");
      end
      if (CODE_W >= REG_W) begin : g_bad_reg
         $error("code field wider than register");
      end
   endgenerate

   logic [CODE_W-1:0] code_pend, code_cur;
   rate_e             rate_cur, rate_nxt;
   logic [ADV_W-1:0]  adv_load;
   logic [POS_W-1:0]  pos_q, pos_nxt;

   tdm_adv_cfg #(
      .REG_W(REG_W), .CODE_W(CODE_W), .ADV_W(ADV_W),
      .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_sel(rate_sel),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .code_pend(code_pend), .code_cur(code_cur),
      .rate_cur(rate_cur), .rate_nxt(rate_nxt), .adv_load(adv_load)
   );

   tdm_adv_timer #(.POS_W(POS_W), .ADV_W(ADV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .adv_load(adv_load),
      .pos_nxt(pos_nxt), .pos_q(pos_q)
   );

   tdm_adv_shifter #(
      .POS_W(POS_W), .FRAME_CYC(FRAME_CYC), .FAST_LOG(FAST_LOG),
      .BYTE_W(BYTE_W), .CH_W(CH_W)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .pos_q(pos_q), .pos_nxt(pos_nxt),
      .rate_cur(rate_cur), .rate_nxt(rate_nxt), .byte_data(byte_data),
      .byte_req(byte_req), .byte_chan(byte_chan), .ser_o(ser_o)
   );

endmodule

// File: rtl/tdm_adv_chk.sv
module tdm_adv_chk #(
   parameter int POS_W    = 14,
   parameter int CODE_W   = 2,
   parameter int FAST_CPB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fp_i,
   input logic              ser_o,
   input logic              byte_req,
   input logic [POS_W-1:0]  pos_q,
   input logic [CODE_W-1:0] code_pend,
   input logic [CODE_W-1:0] code_cur
);

   logic fp_d;
   always_ff @(posedge clk) begin
      if (!rst_n) fp_d <= 1'b0;
      else        fp_d <= fp_i;
   end

   assert_zero_code_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_i && code_pend == '0) |=> (pos_q == '0));

   assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fp_i |=> $stable(code_cur));

   // every bit length is a multiple of the fastest one
   assert_edge_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_o) |-> (fp_d || ((pos_q & POS_W'(FAST_CPB - 1)) == '0)));

   assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req |=> !byte_req);

endmodule

bind tdm_adv_tx tdm_adv_chk #(.POS_W(POS_W), .CODE_W(CODE_W), .FAST_CPB(FAST_CPB)) u_chk (
   .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .ser_o(ser_o), .byte_req(byte_req),
   .pos_q(pos_q), .code_pend(code_pend), .code_cur(code_cur)
);

// File: tb/tdm_adv_tx_bench.sv
module tdm_adv_tx_bench;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 1024;
   localparam int CHW        = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fp_i = 1'b0;
   logic [2:0]     rate_sel = 3'd0;
   logic           cfg_we = 1'b0;
   logic [15:0]    cfg_wdata = 16'h0;
   logic           byte_req;
   logic [CHW-1:0] byte_chan;
   logic [7:0]     byte_data = 8'h0;
   logic           ser_o;
   int             tests = 0;
   int             fails = 0;
   int             salt = 0;
   bit             done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tdm_adv_tx #(.FRAME_CYC(FRAME)) u_tdm_adv_tx (
      .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_sel(rate_sel),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .byte_req(byte_req),
      .byte_chan(byte_chan), .byte_data(byte_data), .ser_o(ser_o)
   );

   function automatic int rate_idx(input logic [2:0] s);
      return (s >= 3'd4) ? 4 : int'(s);
   endfunction
   function automatic int cpb(input int r);
      return 4 << (4 - r);
   endfunction
   function automatic int adv(input int c, input int r);
      return (r == 4) ? c : 2 * c;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // byte source: answers a request with a channel-dependent pattern
   always @(negedge clk) if (byte_req) byte_data <= 8'(int'(byte_chan) * 29 + salt);

   // behavioural reference
   int       m_pos, m_pend, m_code, m_rate;
   logic [7:0] m_hold, m_cur;
   bit       m_reqd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_pend = 0; m_code = 0; m_rate = 0;
         m_hold = 0; m_cur = 0; m_reqd = 0;
      end else begin
         int cp;
         bit oreq;
         logic [7:0] oh;
         cp   = cpb(m_rate);
         oreq = (m_pos % (8 * cp)) == 7 * cp;
         oh   = m_hold;
         if (m_reqd) m_hold = byte_data;
         m_reqd = oreq;
         if (fp_i) begin
            m_code = m_pend;
            m_rate = rate_idx(rate_sel);
            m_pos  = adv(m_code, m_rate);
            m_cur  = oh;
         end else begin
            m_pos = (m_pos + 1) % FRAME;
            cp = cpb(m_rate);
            if (m_pos % (8 * cp) == 0) m_cur = oh;
         end
         if (cfg_we) m_pend = int'(cfg_wdata[1:0]);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int cp, echan;
         bit ereq, eser;
         cp    = cpb(m_rate);
         ereq  = (m_pos % (8 * cp)) == 7 * cp;
         echan = ((m_pos / (8 * cp)) + 1) % (FRAME / (8 * cp));
         eser  = m_cur[7 - ((m_pos / cp) % 8)];
         check(ser_o == eser, "R6 R7 ser_o bit", int'(ser_o), int'(eser));
         check(byte_req == ereq, "R8 byte_req timing", int'(byte_req), int'(ereq));
         check(int'(byte_chan) == echan, "R8 byte_chan index", int'(byte_chan), echan);
      end
   end

   task automatic write_code(input logic [15:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // pulse, then count cycles from the first post-pulse cycle to the request
   task automatic pulse_measure(input int expv, input string tag, input int idle);
      int n;
      @(negedge clk); fp_i = 1'b1;
      @(negedge clk); fp_i = 1'b0;
      n = 0;
      while (!byte_req && n < 2000) begin @(negedge clk); n++; end
      check(n == expv, tag, n, expv);
      repeat (idle) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(ser_o == 1'b0, "R9 reset ser_o", int'(ser_o), 0);
      check(byte_req == 1'b0, "R9 reset byte_req", int'(byte_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_o == 1'b0, "R9 post-reset ser_o", int'(ser_o), 0);

      // R1 R2: reserved bits set with code 00 at 2 Mbps
      write_code(16'hFFFC);
      pulse_measure(7 * 64, "R1 R2 code 00 reserved bits set", 600);
      pulse_measure(7 * 64, "R2 code 00 periodic", 600);

      for (int r = 0; r < 5; r++) begin
         for (int c = 0; c < 4; c++) begin
            salt = r * 7 + c;
            write_code(16'(c));
            rate_sel = 3'(r);
            pulse_measure(7 * cpb(r) - adv(c, r),
                          (r == 4) ? "R4 32M advance" : "R3 slow advance",
                          FRAME - 7 * cpb(r) - 8);
         end
      end

      // R4: selector 6 folds onto 32 Mbps
      rate_sel = 3'd6;
      write_code(16'h0003);
      pulse_measure(28 - 3, "R4 rate_sel 6 as 32M", FRAME - 40);

      // R5: write coinciding with the pulse applies one frame later
      rate_sel = 3'd4;
      write_code(16'h0001);
      pulse_measure(27, "R5 pending code 01", FRAME - 40);
      @(negedge clk); fp_i = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h0003;
      @(negedge clk); fp_i = 1'b0; cfg_we = 1'b0;
      begin
         int n = 0;
         while (!byte_req && n < 2000) begin @(negedge clk); n++; end
         check(n == 27, "R5 same-cycle write not yet applied", n, 27);
      end
      repeat (FRAME - 40) @(negedge clk);
      pulse_measure(25, "R5 write applied next frame", FRAME - 40);

      // R5: rate change without a pulse has no effect on request spacing
      rate_sel = 3'd0;
      repeat (200) @(negedge clk);

      // R10: mid-frame restart at 8 Mbps code 10
      write_code(16'h0002);
      rate_sel = 3'd2;
      pulse_measure(112 - 4, "R10 first pulse", 300);
      pulse_measure(112 - 4, "R10 mid-frame restart", FRAME);

      repeat (50) @(negedge clk);
      finish_run();
   end

endmodule